// File: doc/BRIEF.md
# Clock Stop and Power-Down Gating

This block decides, for every output of a multi-output clock generator, whether that output runs, and it gates the clock cleanly. Three asynchronous active-low requests reach it from the board: power-down, CPU-clock stop and PCI-clock stop. Static configuration bits mask these requests for each output. The configuration holds an enable bit for every output that has one. It also holds a free-run bit for each CPU pair, where 1 means the pair ignores the CPU stop. Each PCI-fixed output has a stop-permit bit, where 1 means the output obeys the PCI stop. The two masks have opposite senses, and the block keeps them separate.

For every CPU differential pair the block reports a drive mode. In RUN the pair toggles. In PARK the true leg is held at doubled reference current and the complement floats. In OFF the pair is disabled. Every other output gets a gated clock. The block also drives an oscillator/VCO run enable that drops during power-down. The requests pass through two-flop synchronizers and are decoded into registered enables on the control clock. Each gated output resamples its enable on the falling edge of its own source clock, so it only ever starts or stops between complete high pulses.

Top module: `ckg_stop_gate`

## Requirements
- R1: While power-down is low, the gated 3V66, 66-buffer, PCI-fixed, PCI, USB and DOT clocks stay low, whatever the enable bits are.
- R2: While power-down is low, `osc_run` is 0 and every enabled CPU pair reports PARK (code 2'b10).
- R3: With power-down high and CPU stop low, an enabled CPU pair whose free-run bit is 0 reports PARK. An enabled pair whose free-run bit is 1 reports RUN (code 2'b01). All non-CPU outputs keep running.
- R4: With power-down high and PCI stop low, all PCI clocks are held low. A PCI-fixed clock is held low only if its stop-permit bit is 1; with the bit at 0 it keeps running.
- R5: An enable bit of 0 turns its output off under every request state: a CPU pair reports OFF (code 2'b00) and a gated clock stays low. An enable bit of 1 lets the stop logic decide.
- R6: With all requests high and all enables set, every CPU pair reports RUN, `osc_run` is 1, and each gated clock equals its source clock during the high phase.
- R7: A gated clock's enable changes only while its source clock is low. Every gated clock is low throughout the low phase of its source.
- R8: A request change that is set up before a control-clock rising edge reaches `cpu_mode` and `osc_run` at the third rising edge. It reaches a gated clock at the next falling edge of that clock's source after that.
- R9: While `rst` is high, every CPU pair reports OFF, `osc_run` is 0 and all gated clocks are low.

Bit i of every vector port belongs to output i. `cpu_mode` bits [2i+1:2i] belong to CPU pair i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for synchronizers and decode |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn_n | input | 1 | Asynchronous power-down request, active low |
| cpustop_n | input | 1 | Asynchronous CPU-clock stop request, active low |
| pcistop_n | input | 1 | Asynchronous PCI-clock stop request, active low |
| cpu_en | input | N_CPU | CPU pair enables, 1 = enabled |
| cpu_free | input | N_CPU | CPU free-run bits, 1 = ignore CPU stop |
| pcif_en | input | N_PCIF | PCI-fixed enables, 1 = enabled |
| pcif_stoppable | input | N_PCIF | PCI-fixed stop permits, 1 = obey PCI stop |
| pci_en | input | N_PCI | PCI enables, 1 = enabled |
| usb_en | input | 1 | USB clock enable |
| dot_en | input | 1 | DOT clock enable |
| src_cpu | input | 1 | CPU source clock |
| src_66 | input | 1 | 66 MHz source clock |
| src_pci | input | 1 | PCI source clock |
| src_48 | input | 1 | 48 MHz source clock |
| cpu_mode | output | 2*N_CPU | Per-pair drive mode: 00 OFF, 01 RUN, 10 PARK |
| cpu_gclk | output | N_CPU | Gated CPU clocks (toggle only in RUN) |
| v66_gclk | output | N_V66 | Gated 3V66 clocks |
| buf66_gclk | output | N_BUF | Gated 66-buffer clocks |
| pcif_gclk | output | N_PCIF | Gated PCI-fixed clocks |
| pci_gclk | output | N_PCI | Gated PCI clocks |
| usb_gclk | output | 1 | Gated USB clock |
| dot_gclk | output | 1 | Gated DOT clock |
| osc_run | output | 1 | Oscillator/VCO run enable |

## Verification
A request change passes two synchronizer flops and one decode register. Its effect on `cpu_mode` and `osc_run` is therefore due three control-clock rising edges after it is applied, and on a gated clock one falling source edge later. The bench ties all source clocks to the control clock and changes inputs only in the high phase. It has one directed case that checks the old value after the second edge, the new mode after the third, and the new gated clock in the high phase after the fourth. Every other stimulus, whether directed or random, is given five edges to settle before the outputs are compared with the bench's model. Gated clocks are sampled in the middle of the high phase, and once in the low phase, where they must all read zero.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

    typedef enum logic [1:0] {
        CPU_OFF  = 2'b00,
        CPU_RUN  = 2'b01,
        CPU_PARK = 2'b10
    } cpu_mode_e;

    // Active-high request view after synchronization
    typedef struct packed {
        logic pd;
        logic cpu_stop;
        logic pci_stop;
    } stop_req_t;

    // Drive mode of one CPU pair: disable wins, then power-down, then masked stop
    function automatic cpu_mode_e cpu_mode_f(input logic en, input logic free,
                                             input stop_req_t req);
        if (!en)
            return CPU_OFF;
        if (req.pd)
            return CPU_PARK;
        if (req.cpu_stop && !free)
            return CPU_PARK;
        return CPU_RUN;
    endfunction

endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/ckg_decode.sv
module ckg_decode
    import ckg_pkg::*;
#(
    parameter int N_CPU  = 3,
    parameter int N_V66  = 2,
    parameter int N_BUF  = 4,
    parameter int N_PCIF = 3,
    parameter int N_PCI  = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  stop_req_t                 req,
    input  logic [N_CPU-1:0]          cpu_en,
    input  logic [N_CPU-1:0]          cpu_free,
    input  logic [N_PCIF-1:0]         pcif_en,
    input  logic [N_PCIF-1:0]         pcif_stoppable,
    input  logic [N_PCI-1:0]          pci_en,
    input  logic                      usb_en,
    input  logic                      dot_en,
    output cpu_mode_e [N_CPU-1:0]     mode_q,
    output logic [N_V66-1:0]          v66_en_q,
    output logic [N_BUF-1:0]          buf_en_q,
    output logic [N_PCIF-1:0]         pcif_en_q,
    output logic [N_PCI-1:0]          pci_en_q,
    output logic                      usb_en_q,
    output logic                      dot_en_q,
    output logic                      osc_run_q
);
    cpu_mode_e [N_CPU-1:0] mode_d;
    logic [N_PCIF-1:0]     pcif_d;

    always_comb begin
        for (int i = 0; i < N_CPU; i++)
            mode_d[i] = cpu_mode_f(cpu_en[i], cpu_free[i], req);
        for (int i = 0; i < N_PCIF; i++)
            pcif_d[i] = pcif_en[i] && !req.pd && !(req.pci_stop && pcif_stoppable[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= {N_CPU{CPU_OFF}};
            v66_en_q  <= '0;
            buf_en_q  <= '0;
            pcif_en_q <= '0;
            pci_en_q  <= '0;
            usb_en_q  <= 1'b0;
            dot_en_q  <= 1'b0;
            osc_run_q <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            v66_en_q  <= {N_V66{!req.pd}};
            buf_en_q  <= {N_BUF{!req.pd}};
            pcif_en_q <= pcif_d;
            pci_en_q  <= pci_en & {N_PCI{!req.pd && !req.pci_stop}};
            usb_en_q  <= usb_en && !req.pd;
            dot_en_q  <= dot_en && !req.pd;
            osc_run_q <= !req.pd;
        end
    end

    // R1: power-down quiets every non-CPU enable on the next edge
    p_pd_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req.pd |=> (v66_en_q == '0 && buf_en_q == '0 && pcif_en_q == '0 &&
                    pci_en_q == '0 && !usb_en_q && !dot_en_q));

    // R2: power-down stops the oscillator
    p_pd_osc_r2: assert property (@(posedge clk) disable iff (rst)
        req.pd |=> !osc_run_q);

    // R4: PCI stop clears all PCI enables
    p_pci_stop_r4: assert property (@(posedge clk) disable iff (rst)
        req.pci_stop |=> pci_en_q == '0);

    for (genvar g = 0; g < N_CPU; g++) begin : g_cpu_chk
        // R2: an enabled pair never runs in power-down
        p_pd_park_r2: assert property (@(posedge clk) disable iff (rst)
            (req.pd && cpu_en[g]) |=> mode_q[g] == CPU_PARK);
        // R3: a free-running pair ignores the CPU stop
        p_free_run_r3: assert property (@(posedge clk) disable iff (rst)
            (!req.pd && req.cpu_stop && cpu_en[g] && cpu_free[g]) |=> mode_q[g] == CPU_RUN);
        // R5: a disabled pair is off
        p_disabled_off_r5: assert property (@(posedge clk) disable iff (rst)
            !cpu_en[g] |=> mode_q[g] == CPU_OFF);
    end
endmodule

// File: rtl/ckg_gate_bank.sv
module ckg_gate_bank #(
    parameter int W = 2
) (
    input  logic         src,
    input  logic         rst,
    input  logic [W-1:0] en,
    output logic [W-1:0] gclk
);
    logic [W-1:0] en_q;
    logic [W-1:0] rise_q;

    for (genvar g = 0; g < W; g++) begin : g_gate
        // Enable retimed while the source is low: no partial high pulse
        always_ff @(negedge src) begin
            if (rst)
                en_q[g] <= 1'b0;
            else
                en_q[g] <= en[g];
        end
        assign gclk[g] = src & en_q[g];
    end

    always_ff @(posedge src)
        rise_q <= en_q;

    // R7: the enable seen at the rising edge is still in place at the falling edge
    p_no_runt_r7: assert property (@(negedge src) disable iff (rst)
        en_q == rise_q);
endmodule

// File: rtl/ckg_stop_gate.sv
module ckg_stop_gate
    import ckg_pkg::*;
#(
    parameter int N_CPU  = 3,
    parameter int N_V66  = 2,
    parameter int N_BUF  = 4,
    parameter int N_PCIF = 3,
    parameter int N_PCI  = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwrdn_n,
    input  logic                 cpustop_n,
    input  logic                 pcistop_n,
    input  logic [N_CPU-1:0]     cpu_en,
    input  logic [N_CPU-1:0]     cpu_free,
    input  logic [N_PCIF-1:0]    pcif_en,
    input  logic [N_PCIF-1:0]    pcif_stoppable,
    input  logic [N_PCI-1:0]     pci_en,
    input  logic                 usb_en,
    input  logic                 dot_en,
    input  logic                 src_cpu,
    input  logic                 src_66,
    input  logic                 src_pci,
    input  logic                 src_48,
    output logic [2*N_CPU-1:0]   cpu_mode,
    output logic [N_CPU-1:0]     cpu_gclk,
    output logic [N_V66-1:0]     v66_gclk,
    output logic [N_BUF-1:0]     buf66_gclk,
    output logic [N_PCIF-1:0]    pcif_gclk,
    output logic [N_PCI-1:0]     pci_gclk,
    output logic                 usb_gclk,
    output logic                 dot_gclk,
    output logic                 osc_run
);
    localparam int N_66B  = N_V66 + N_BUF;
    localparam int N_PCIB = N_PCIF + N_PCI;

    logic [2:0]            req_n_s;
    stop_req_t             req;
    cpu_mode_e [N_CPU-1:0] mode_q;
    logic [N_V66-1:0]      v66_en_q;
    logic [N_BUF-1:0]      buf_en_q;
    logic [N_PCIF-1:0]     pcif_en_q;
    logic [N_PCI-1:0]      pci_en_q;
    logic                  usb_en_q;
    logic                  dot_en_q;
    logic [N_CPU-1:0]      cpu_run;

    ckg_sync #(.W(3), .RST_VAL(3'b111)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pwrdn_n, cpustop_n, pcistop_n}),
        .q   (req_n_s)
    );

    assign req = '{pd: !req_n_s[2], cpu_stop: !req_n_s[1], pci_stop: !req_n_s[0]};

    ckg_decode #(
        .N_CPU(N_CPU), .N_V66(N_V66), .N_BUF(N_BUF), .N_PCIF(N_PCIF), .N_PCI(N_PCI)
    ) i_decode (
        .clk            (clk),
        .rst            (rst),
        .req            (req),
        .cpu_en         (cpu_en),
        .cpu_free       (cpu_free),
        .pcif_en        (pcif_en),
        .pcif_stoppable (pcif_stoppable),
        .pci_en         (pci_en),
        .usb_en         (usb_en),
        .dot_en         (dot_en),
        .mode_q         (mode_q),
        .v66_en_q       (v66_en_q),
        .buf_en_q       (buf_en_q),
        .pcif_en_q      (pcif_en_q),
        .pci_en_q       (pci_en_q),
        .usb_en_q       (usb_en_q),
        .dot_en_q       (dot_en_q),
        .osc_run_q      (osc_run)
    );

    for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
        assign cpu_mode[2*g +: 2] = mode_q[g];
        assign cpu_run[g]         = (mode_q[g] == CPU_RUN);
    end

    ckg_gate_bank #(.W(N_CPU)) i_gate_cpu (
        .src (src_cpu), .rst (rst), .en (cpu_run), .gclk (cpu_gclk)
    );

    ckg_gate_bank #(.W(N_66B)) i_gate_66 (
        .src (src_66), .rst (rst), .en ({buf_en_q, v66_en_q}), .gclk ({buf66_gclk, v66_gclk})
    );

    ckg_gate_bank #(.W(N_PCIB)) i_gate_pci (
        .src (src_pci), .rst (rst), .en ({pci_en_q, pcif_en_q}), .gclk ({pci_gclk, pcif_gclk})
    );

    ckg_gate_bank #(.W(2)) i_gate_48 (
        .src (src_48), .rst (rst), .en ({dot_en_q, usb_en_q}), .gclk ({dot_gclk, usb_gclk})
    );
endmodule

// File: tb/test_ckg_stop_gate.sv
module test_ckg_stop_gate;
    localparam int N_CPU = 3, N_V66 = 2, N_BUF = 4, N_PCIF = 3, N_PCI = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwrdn_n = 1'b1, cpustop_n = 1'b1, pcistop_n = 1'b1;
    logic [N_CPU-1:0]  cpu_en = '1, cpu_free = '0;
    logic [N_PCIF-1:0] pcif_en = '1, pcif_stoppable = '0;
    logic [N_PCI-1:0]  pci_en = '1;
    logic usb_en = 1'b1, dot_en = 1'b1;

    logic [2*N_CPU-1:0] cpu_mode;
    logic [N_CPU-1:0]   cpu_gclk;
    logic [N_V66-1:0]   v66_gclk;
    logic [N_BUF-1:0]   buf66_gclk;
    logic [N_PCIF-1:0]  pcif_gclk;
    logic [N_PCI-1:0]   pci_gclk;
    logic usb_gclk, dot_gclk, osc_run;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ckg_stop_gate #(.N_CPU(N_CPU), .N_V66(N_V66), .N_BUF(N_BUF), .N_PCIF(N_PCIF), .N_PCI(N_PCI))
    i_ckg_stop_gate (
        .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .cpustop_n(cpustop_n), .pcistop_n(pcistop_n),
        .cpu_en(cpu_en), .cpu_free(cpu_free), .pcif_en(pcif_en), .pcif_stoppable(pcif_stoppable),
        .pci_en(pci_en), .usb_en(usb_en), .dot_en(dot_en),
        .src_cpu(clk), .src_66(clk), .src_pci(clk), .src_48(clk),
        .cpu_mode(cpu_mode), .cpu_gclk(cpu_gclk), .v66_gclk(v66_gclk), .buf66_gclk(buf66_gclk),
        .pcif_gclk(pcif_gclk), .pci_gclk(pci_gclk), .usb_gclk(usb_gclk), .dot_gclk(dot_gclk),
        .osc_run(osc_run)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected CPU mode: 00 off, 01 run, 10 park
    function automatic logic [1:0] m_mode(input logic en, input logic fr);
        if (!en) return 2'b00;
        if (!pwrdn_n) return 2'b10;
        if (!cpustop_n && !fr) return 2'b10;
        return 2'b01;
    endfunction

    function automatic logic [2*N_CPU-1:0] m_modes();
        logic [2*N_CPU-1:0] r;
        for (int i = 0; i < N_CPU; i++) r[2*i +: 2] = m_mode(cpu_en[i], cpu_free[i]);
        return r;
    endfunction

    function automatic logic [N_CPU-1:0] m_cpu_run();
        logic [N_CPU-1:0] r;
        for (int i = 0; i < N_CPU; i++) r[i] = (m_mode(cpu_en[i], cpu_free[i]) == 2'b01);
        return r;
    endfunction

    function automatic logic [N_PCIF-1:0] m_pcif();
        return pcif_en & {N_PCIF{pwrdn_n}} & ~(pcif_stoppable & {N_PCIF{!pcistop_n}});
    endfunction

    function automatic logic [N_PCI-1:0] m_pci();
        return pci_en & {N_PCI{pwrdn_n && pcistop_n}};
    endfunction

    // Called in the high phase after the outputs have settled
    task automatic check_all(input string tag);
        chk({tag, " R2/R3/R5 cpu_mode"}, 32'(cpu_mode), 32'(m_modes()));
        chk({tag, " R2 osc_run"}, 32'(osc_run), 32'(pwrdn_n));
        chk({tag, " R6 cpu_gclk"}, 32'(cpu_gclk), 32'(m_cpu_run()));
        chk({tag, " R1 v66/buf66"}, 32'({buf66_gclk, v66_gclk}), 32'({(N_V66+N_BUF){pwrdn_n}}));
        chk({tag, " R4 pcif_gclk"}, 32'(pcif_gclk), 32'(m_pcif()));
        chk({tag, " R4 pci_gclk"}, 32'(pci_gclk), 32'(m_pci()));
        chk({tag, " R5 usb/dot"}, 32'({dot_gclk, usb_gclk}), 32'({dot_en && pwrdn_n, usb_en && pwrdn_n}));
    endtask

    task automatic settle_check(input string tag);
        repeat (5) @(posedge clk);
        #2;
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        // R9: reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R9 mode in reset", 32'(cpu_mode), 32'd0);
        chk("R9 osc in reset", 32'(osc_run), 32'd0);
        chk("R9 gclk in reset", 32'({cpu_gclk, v66_gclk, buf66_gclk, pcif_gclk, pci_gclk, usb_gclk, dot_gclk}), 32'd0);
        rst = 1'b0;

        // R6: normal running
        settle_check("R6 normal");
        chk("R6 all run", 32'(cpu_mode), 32'({N_CPU{2'b01}}));
        // R7: low phase is low everywhere
        @(negedge clk); #2;
        chk("R7 low phase", 32'({cpu_gclk, v66_gclk, buf66_gclk, pcif_gclk, pci_gclk, usb_gclk, dot_gclk}), 32'd0);

        // R8: latency of a power-down request
        @(posedge clk); #2;
        pwrdn_n = 1'b0;
        repeat (2) @(posedge clk); #2;
        chk("R8 osc old after 2 edges", 32'(osc_run), 32'd1);
        @(posedge clk); #2;
        chk("R8 osc new after 3 edges", 32'(osc_run), 32'd0);
        chk("R8 mode new after 3 edges", 32'(cpu_mode), 32'({N_CPU{2'b10}}));
        chk("R8 gclk old in same high phase", 32'(v66_gclk), 32'({N_V66{1'b1}}));
        @(posedge clk); #2;
        chk("R8 gclk new after falling edge", 32'(v66_gclk), 32'd0);

        // R1/R2: power-down with a disabled pair and stops asserted too
        cpu_en = 3'b101; cpustop_n = 1'b0; pcistop_n = 1'b0;
        settle_check("R1 pd");
        chk("R1 pd pci_gclk low", 32'(pci_gclk), 32'd0);

        // R3: CPU stop with mixed free-run
        pwrdn_n = 1'b1; pcistop_n = 1'b1; cpu_en = '1; cpu_free = 3'b010;
        settle_check("R3 cpustop");
        chk("R3 pair1 runs pair0/2 park", 32'(cpu_mode), 32'({2'b10, 2'b01, 2'b10}));

        // R4: PCI stop with mixed permits
        cpustop_n = 1'b1; pcistop_n = 1'b0; pcif_stoppable = 3'b101;
        settle_check("R4 pcistop");
        chk("R4 pcif1 free running", 32'(pcif_gclk), 32'(3'b010));

        // R5: disabled outputs stay off with no stop requested
        pcistop_n = 1'b1; cpu_en = 3'b011; pci_en = 7'b1010101; pcif_en = 3'b110; usb_en = 1'b0;
        settle_check("R5 disabled");
        chk("R5 pair2 off", 32'(cpu_mode[5:4]), 32'd0);

        // Constrained random mix
        for (int it = 0; it < 60; it++) begin
            logic [31:0] r;
            r = $urandom;
            pwrdn_n   = (r[3:0] != 4'd0);
            cpustop_n = r[4] | r[5];
            pcistop_n = r[6] | r[7];
            cpu_en = r[10:8]; cpu_free = r[13:11];
            pcif_en = r[16:14]; pcif_stoppable = r[19:17];
            pci_en = r[26:20]; usb_en = r[27]; dot_en = r[28];
            settle_check("rand");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule